// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of signed integer samples into a one-bit delta code. For each sample it accepts, it decides whether the sample lies above its running estimate of the signal. It then moves that estimate one step up or one step down and reports both the decision bit and the new estimate. The estimate is kept in signed fixed point with fractional bits, so the step size can shrink and grow in steps smaller than one input LSB.

Two behaviours are available, and the block latches its choice while reset is held. In linear mode every step is exactly one input LSB. In adaptive mode the step follows the run of decisions. When the decision repeats, the next step is the previous step times 147/128, which approximates 1.15. When the decision reverses, the step is halved. The step can never fall below one input LSB, and it never exceeds a cap taken from a port. The estimate saturates at its signed limits instead of wrapping.

Top module: `adm_encoder`

## Requirements
- R1: The output bit is 1 (step up) when the sample, scaled to the estimate format, minus the current estimate is strictly positive. Otherwise the bit is 0 (step down), so a sample equal to the estimate produces a down step.
- R2: In linear mode every accepted sample changes the estimate by exactly one input LSB (256 raw units with 8 fractional bits), up or down as R1 decides.
- R3: After reset the estimate is 0, out_valid is 0, and the stored decision (out_bit) is 1. In adaptive mode the first accepted sample after reset moves the estimate by the minimum step of one input LSB.
- R4: In adaptive mode, when the new decision equals the previous one, the step magnitude is floor(previous magnitude × 147 / 128).
- R5: In adaptive mode, when the new decision differs from the previous one, the step magnitude is floor(previous magnitude / 2).
- R6: The step magnitude is first capped at max_step (in raw estimate units) and then raised to at least one input LSB. When max_step is below one LSB, the floor wins.
- R7: The estimate saturates at the most negative and most positive values of its width and never wraps.
- R8: out_valid rises exactly one cycle after an accepted sample. A cycle without in_valid leaves the estimate and the decision unchanged and gives out_valid 0 in the following cycle.
- R9: mode_adapt is sampled only while reset is asserted. Changing it afterwards has no effect until the next reset.
- R10: With a sine input of amplitude 10 sampled at 101 evenly spaced points over one period, the decisions and estimates match the behavioural model in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; mode_adapt is latched while it is high |
| mode_adapt | input | 1 | 1 selects adaptive step, 0 selects the fixed one-LSB step |
| max_step | input | EST_W-1 | Upper bound on the step magnitude, raw estimate units |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed integer sample |
| out_valid | output | 1 | High one cycle after an accepted sample |
| out_bit | output | 1 | Latest decision: 1 up, 0 down |
| out_estimate | output | EST_W | Signed estimate with FRAC_W fractional bits |

## Verification
The bench builds the block with 8-bit samples, 8 fractional bits and the 147/128 growth factor. This gives a 16-bit estimate and a 15-bit cap. With these sizes, a run of repeated down decisions drives the estimate into its negative limit within a few dozen samples. A small cap makes the floor-versus-cap ordering visible in a handful of steps. Directed step chains are checked against hand-computed growth and halving values. Seeded random bursts with idle gaps and changing caps exercise both modes against a bench model.

// File: rtl/adm_pkg.sv
package adm_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } adm_dir_e;

    typedef enum logic {
        MODE_LINEAR   = 1'b0,
        MODE_ADAPTIVE = 1'b1
    } adm_mode_e;
endpackage

// File: rtl/adm_decide.sv
module adm_decide #(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 8,
    localparam int EST_W = DATA_W + FRAC_W
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [EST_W-1:0]  est,
    output adm_pkg::adm_dir_e        dir
);
    logic signed [EST_W:0] sample_w;
    logic signed [EST_W:0] est_w;
    logic signed [EST_W:0] diff;

    always_comb begin
        sample_w = {sample[DATA_W-1], sample, {FRAC_W{1'b0}}};
        est_w    = {est[EST_W-1], est};
        diff     = sample_w - est_w;
        // Only a strictly positive difference counts as up.
        dir      = (!diff[EST_W] && (diff != '0)) ? adm_pkg::DIR_UP : adm_pkg::DIR_DOWN;
    end
endmodule

// File: rtl/adm_step_calc.sv
module adm_step_calc #(
    parameter int STEP_W     = 15,
    parameter int GROW_NUM   = 147,
    parameter int GROW_SHIFT = 7,
    parameter int MIN_STEP   = 256,
    localparam int GROW_W    = $clog2(GROW_NUM + 1),
    localparam int WIDE_W    = STEP_W + GROW_W
) (
    input  logic              adaptive,
    input  logic              first,
    input  logic              same_dir,
    input  logic [STEP_W-1:0] last_mag,
    input  logic [STEP_W-1:0] max_step,
    output logic [STEP_W-1:0] mag
);
    logic [WIDE_W-1:0] last_w;
    logic [WIDE_W-1:0] prod_w;
    logic [WIDE_W-1:0] grown_w;
    logic [WIDE_W-1:0] halved_w;
    logic [WIDE_W-1:0] pick_w;
    logic [WIDE_W-1:0] capped_w;
    logic [WIDE_W-1:0] floor_w;

    always_comb begin
        last_w   = WIDE_W'(last_mag);
        prod_w   = last_w * WIDE_W'(GROW_NUM);
        grown_w  = prod_w >> GROW_SHIFT;
        halved_w = last_w >> 1;
        floor_w  = WIDE_W'(MIN_STEP);
        if (!adaptive || first) begin
            pick_w = floor_w;
        end else if (same_dir) begin
            pick_w = grown_w;
        end else begin
            pick_w = halved_w;
        end
        // Cap first, then the floor, so the floor wins on a tiny cap.
        capped_w = (pick_w > WIDE_W'(max_step)) ? WIDE_W'(max_step) : pick_w;
        if (capped_w < floor_w) begin
            capped_w = floor_w;
        end
        mag = STEP_W'(capped_w);
    end
endmodule

// File: rtl/adm_sat_add.sv
module adm_sat_add #(
    parameter int EST_W   = 16,
    localparam int STEP_W = EST_W - 1
) (
    input  logic [EST_W-1:0]  est,
    input  logic [STEP_W-1:0] mag,
    input  adm_pkg::adm_dir_e dir,
    output logic [EST_W-1:0]  est_next
);
    localparam logic signed [EST_W:0] HI_LIM = $signed({2'b00, {(EST_W-1){1'b1}}});
    localparam logic signed [EST_W:0] LO_LIM = $signed({2'b11, {(EST_W-1){1'b0}}});

    logic signed [EST_W:0] est_w;
    logic signed [EST_W:0] mag_w;
    logic signed [EST_W:0] sum_w;

    always_comb begin
        est_w = {est[EST_W-1], est};
        mag_w = {2'b00, mag};
        sum_w = (dir == adm_pkg::DIR_UP) ? (est_w + mag_w) : (est_w - mag_w);
        if (sum_w > HI_LIM) begin
            est_next = HI_LIM[EST_W-1:0];
        end else if (sum_w < LO_LIM) begin
            est_next = LO_LIM[EST_W-1:0];
        end else begin
            est_next = sum_w[EST_W-1:0];
        end
    end
endmodule

// File: rtl/adm_encoder.sv
module adm_encoder #(
    parameter int DATA_W     = 8,
    parameter int FRAC_W     = 8,
    parameter int GROW_NUM   = 147,
    parameter int GROW_SHIFT = 7,
    localparam int EST_W     = DATA_W + FRAC_W,
    localparam int STEP_W    = EST_W - 1,
    localparam int MIN_STEP  = 1 << FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_adapt,
    input  logic [STEP_W-1:0]        max_step,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic                     out_bit,
    output logic [EST_W-1:0]         out_estimate
);
    import adm_pkg::*;

    typedef struct packed {
        adm_mode_e         mode;
        logic              first;
        adm_dir_e          dir;
        logic [STEP_W-1:0] mag;
        logic [EST_W-1:0]  est;
        logic              vld;
    } adm_state_t;

    adm_state_t st_q;
    adm_state_t st_d;
    adm_state_t st_rst;

    adm_dir_e          dir_new;
    logic [STEP_W-1:0] mag_new;
    logic [EST_W-1:0]  est_new;

    adm_decide #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_decide (
        .sample (in_data),
        .est    (st_q.est),
        .dir    (dir_new)
    );

    adm_step_calc #(
        .STEP_W     (STEP_W),
        .GROW_NUM   (GROW_NUM),
        .GROW_SHIFT (GROW_SHIFT),
        .MIN_STEP   (MIN_STEP)
    ) u_step (
        .adaptive (st_q.mode == MODE_ADAPTIVE),
        .first    (st_q.first),
        .same_dir (dir_new == st_q.dir),
        .last_mag (st_q.mag),
        .max_step (max_step),
        .mag      (mag_new)
    );

    adm_sat_add #(.EST_W(EST_W)) u_sat (
        .est      (st_q.est),
        .mag      (mag_new),
        .dir      (dir_new),
        .est_next (est_new)
    );

    always_comb begin
        st_rst       = '0;
        st_rst.mode  = mode_adapt ? MODE_ADAPTIVE : MODE_LINEAR;
        st_rst.first = 1'b1;
        st_rst.dir   = DIR_UP;
        st_rst.mag   = STEP_W'(MIN_STEP);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dir   = dir_new;
            st_d.mag   = mag_new;
            st_d.est   = est_new;
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign out_bit      = (st_q.dir == DIR_UP);
    assign out_estimate = st_q.est;

    // The estimate moves in the direction of the reported decision.
    assert_dir_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_bit ? ($signed(out_estimate) >= $signed($past(out_estimate)))
                              : ($signed(out_estimate) <= $signed($past(out_estimate)))));

    // Linear mode: each change is exactly one LSB unless a limit is hit.
    assert_linear_step_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && st_q.mode == MODE_LINEAR) |=>
        (($signed(out_estimate) - $signed($past(out_estimate)) == MIN_STEP) ||
         ($signed($past(out_estimate)) - $signed(out_estimate) == MIN_STEP) ||
         (out_estimate == {1'b1, {(EST_W-1){1'b0}}}) ||
         (out_estimate == {1'b0, {(EST_W-1){1'b1}}})));

    // The stored step never decays below one input LSB.
    assert_step_floor_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.mag >= STEP_W'(MIN_STEP));

    // A cap at or above the floor bounds the next stored step.
    assert_step_cap_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && max_step >= STEP_W'(MIN_STEP)) |=> (st_q.mag <= $past(max_step)));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_estimate) && $stable(out_bit)));

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(st_q.mode));
endmodule

// File: tb/adm_encoder_bench.sv
module adm_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int FRAC_W     = 8;
    localparam int EST_W      = DATA_W + FRAC_W;
    localparam int STEP_W     = EST_W - 1;
    localparam int LSB        = 1 << FRAC_W;
    localparam int EST_MAX    = (1 << (EST_W - 1)) - 1;
    localparam int EST_MIN    = -(1 << (EST_W - 1));

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_adapt = 1'b0;
    logic [STEP_W-1:0] max_step = '1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_bit;
    logic [EST_W-1:0]  out_estimate;

    int n_chk = 0;
    int n_bad = 0;

    int m_est;
    int m_mag;
    bit m_dir;
    bit m_first;
    bit m_mode;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adm_encoder #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_adm_encoder (
        .clk          (clk),
        .rst          (rst),
        .mode_adapt   (mode_adapt),
        .max_step     (max_step),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_bit      (out_bit),
        .out_estimate (out_estimate)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_est(input int v);
        if (v > EST_MAX) return EST_MAX;
        if (v < EST_MIN) return EST_MIN;
        return v;
    endfunction

    task automatic model_apply(input int x);
        bit up;
        int raw;
        up = ((x * LSB) - m_est) > 0;
        if (!m_mode || m_first)  raw = LSB;
        else if (up == m_dir)    raw = (m_mag * 147) / 128;
        else                     raw = m_mag / 2;
        if (raw > int'(max_step)) raw = int'(max_step);
        if (raw < LSB)            raw = LSB;
        m_est   = sat_est(up ? (m_est + raw) : (m_est - raw));
        m_dir   = up;
        m_mag   = raw;
        m_first = 1'b0;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1; mode_adapt = mode; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_est = 0; m_mag = LSB; m_dir = 1'b1; m_first = 1'b1; m_mode = mode;
    endtask

    // Called at a falling edge; drives, waits one rising edge, samples.
    task automatic send(input bit v, input int x, input string req);
        in_valid = v;
        in_data  = x[DATA_W-1:0];
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (v) model_apply(x);
        chk(out_valid == v, {req, " valid"}, int'(out_valid), int'(v));
        if (v) chk(out_bit == m_dir, {req, " bit"}, int'(out_bit), int'(m_dir));
        chk($signed(out_estimate) == m_est, {req, " estimate"}, $signed(out_estimate), m_est);
    endtask

    task automatic run_sine(input string req);
        for (int k = 0; k <= 100; k++) begin
            int x;
            x = int'($sin(6.283185307179586 * real'(k) / 100.0) * 10.0);
            send(1'b1, x, req);
        end
    endtask

    task automatic run_random(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            if ($urandom_range(0, 15) == 0) max_step = STEP_W'($urandom_range(0, 32767));
            send($urandom_range(0, 3) != 0, int'($signed(DATA_W'($urandom))), req);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        // R3: reset state
        chk(out_valid == 1'b0, "R3 reset valid", int'(out_valid), 0);
        chk(out_estimate == '0, "R3 reset estimate", int'(out_estimate), 0);
        chk(out_bit == 1'b1, "R3 reset decision", int'(out_bit), 1);

        // R1: equal sample and estimate gives a down step
        send(1'b1, 0, "R1");
        chk(out_bit == 1'b0, "R1 zero diff bit", int'(out_bit), 0);
        chk($signed(out_estimate) == -LSB, "R1 zero diff est", $signed(out_estimate), -LSB);

        // R2, R10: linear sine
        do_reset(1'b0);
        run_sine("R2 R10 linear sine");

        // R9: mode change after reset has no effect
        mode_adapt = 1'b1;
        for (int k = 0; k < 20; k++) send(1'b1, (k % 2) ? 40 : -40, "R9 mode frozen");

        // R3, R4, R5: adaptive step chain
        max_step = '1;
        do_reset(1'b1);
        send(1'b1, 50, "R3 first step");
        chk($signed(out_estimate) == LSB, "R3 first step est", $signed(out_estimate), LSB);
        for (int k = 0; k < 9; k++) send(1'b1, 100, "R4 growth");
        chk($signed(out_estimate) == 5133, "R4 grown est", $signed(out_estimate), 5133);
        send(1'b1, -100, "R5 reversal");
        chk($signed(out_estimate) == 4692, "R5 halved est", $signed(out_estimate), 4692);

        // R6: cap then floor
        max_step = 15'd300;
        do_reset(1'b1);
        for (int k = 0; k < 4; k++) send(1'b1, 100, "R6 cap");
        chk($signed(out_estimate) == 1150, "R6 capped est", $signed(out_estimate), 1150);
        max_step = 15'd100;
        send(1'b1, 100, "R6 floor");
        chk($signed(out_estimate) == 1406, "R6 floor wins", $signed(out_estimate), 1406);

        // R7: negative saturation
        max_step = '1;
        do_reset(1'b1);
        for (int k = 0; k < 60; k++) send(1'b1, -128, "R7 saturate");
        chk($signed(out_estimate) == EST_MIN, "R7 limit", $signed(out_estimate), EST_MIN);

        // R10: adaptive sine
        do_reset(1'b1);
        run_sine("R10 adaptive sine");

        // R8 plus random mixes in both modes
        do_reset(1'b0);
        run_random(3000, "R8 random linear");
        max_step = '1;
        do_reset(1'b1);
        run_random(3000, "R8 random adaptive");
        for (int k = 0; k < 5; k++) send(1'b0, 0, "R8 idle");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule